// File: doc/BRIEF.md
# Event-Counting Pulse Sequencer

This block drives a single output pulse once a fixed sequence of events has run its course, and then starts over. It sits idle until it has counted a set number of high-to-low transitions on an asynchronous serial input. It then lets a set number of clock cycles pass, holds its output high for a set number of cycles, and returns to idle. The three counts are parameters. With the defaults it waits for 2 input falls, then 4 cycles, then gives a 3-cycle pulse.

Everything runs on the rising edge of one clock. The serial input first passes through a synchronizer chain. A registered copy of the synchronized value then turns each high-to-low transition into a one-cycle event. A single down-counter serves all three states. It is loaded with the count for a state when the machine enters that state, and it decrements on each event that the current state accepts. When the last event arrives, the machine moves to the next state. The block has no data stream and so no valid/ready handshake: its pins are plain control lines.

The state register uses a binary code. The one code that is never reached leads back to idle. The counts must each be at least 1, and SYNC_STAGES must be at least 2. If the input is held low while reset is released, that counts as one fall, because reset presets the synchronizer to high.

Top module: `pulse_seq_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pulse_o` is 0 after that edge and the machine is idle with a full fall count. With the input held high and no transitions, `pulse_o` stays 0 after reset.
- R2: A fall on `din_async` that is set up before clock edge k is counted at edge k+SYNC_STAGES. A change at the input therefore never shows at the output sooner than SYNC_STAGES+WAIT_CYCLES edges later.
- R3: In idle, exactly FALL_COUNT high-to-low transitions are needed to leave idle. Low-to-high transitions and steady levels, of any length, are not counted.
- R4: `pulse_o` rises at the edge that lies WAIT_CYCLES clock edges after the edge that counted the last idle fall.
- R5: `pulse_o` stays 1 for exactly HIGH_CYCLES cycles. It then drops to 0, and the machine is back in idle needing FALL_COUNT new falls.
- R6: Input falls that occur while the machine waits or pulses are ignored and are not saved. After the pulse ends, the full FALL_COUNT falls are needed again.
- R7: A reset in any state, including in the middle of the wait, in the middle of the pulse, or after a partial fall count, drops `pulse_o` at that edge and discards all progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| din_async | input | 1 | Asynchronous serial input whose falls are counted |
| pulse_o | output | 1 | Registered output pulse, high for HIGH_CYCLES cycles per sequence |

## Verification
The hardest case to reach from the ports is proving that falls arriving during the wait and pulse phases are dropped rather than held back. The stimulus times two full fall transitions so that the synchronizer delivers one of them in the wait phase and one in the pulse phase, and keeps both clear of the return to idle. The bench then watches a long quiet stretch and a single further fall. If either of those produces a pulse, the design stored an event it should have dropped. Resets are also placed inside the wait phase, inside the pulse, and after half a fall count, so that no leftover progress survives a reset.

// File: rtl/pulse_seq_pkg.sv
package pulse_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_HIGH = 2'b10,
    ST_BAD  = 2'b11
  } seq_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/pulse_seq_fall_det.sv
module pulse_seq_fall_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_async,
  output logic fall_o
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  // Reset presets everything high so a high input yields no edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q[0] <= din_async;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[LAST];
    end
  end

  assign fall_o = !sync_q[LAST] && prev_q;

  // R2: a detected fall lasts exactly one cycle
  p_fall_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/pulse_seq_downcnt.sv
module pulse_seq_downcnt #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned RST_VAL = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             dec_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             last_o
);

  localparam logic [WIDTH-1:0] RST_CNT = WIDTH'(RST_VAL);
  localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_o <= RST_CNT;
    else if (load_i) cnt_o <= load_val_i;
    else if (dec_i)  cnt_o <= cnt_o - ONE;
  end

  assign last_o = (cnt_o == ONE);

  // R4: the counter is never asked to step below zero
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i) |-> (cnt_o != '0));

endmodule

// File: rtl/pulse_seq_top.sv
module pulse_seq_top #(
  parameter int unsigned FALL_COUNT  = 2,
  parameter int unsigned WAIT_CYCLES = 4,
  parameter int unsigned HIGH_CYCLES = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_async,
  output logic pulse_o
);

  import pulse_seq_pkg::*;

  localparam int unsigned MAX_COUNT = max3(FALL_COUNT, WAIT_CYCLES, HIGH_CYCLES);
  localparam int unsigned CNT_W     = $clog2(MAX_COUNT + 1);
  localparam logic [CNT_W-1:0] LOAD_FALL = CNT_W'(FALL_COUNT);
  localparam logic [CNT_W-1:0] LOAD_WAIT = CNT_W'(WAIT_CYCLES);
  localparam logic [CNT_W-1:0] LOAD_HIGH = CNT_W'(HIGH_CYCLES);

  seq_state_e       state_q, state_d;
  logic             fall;
  logic             evt;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_load_val;
  logic             cnt_dec;
  logic [CNT_W-1:0] cnt;
  logic             cnt_last;

  pulse_seq_fall_det #(.SYNC_STAGES(SYNC_STAGES)) u_fall (
    .clk       (clk),
    .rst_n     (rst_n),
    .din_async (din_async),
    .fall_o    (fall)
  );

  pulse_seq_downcnt #(.WIDTH(CNT_W), .RST_VAL(FALL_COUNT)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load),
    .load_val_i (cnt_load_val),
    .dec_i      (cnt_dec),
    .cnt_o      (cnt),
    .last_o     (cnt_last)
  );

  // Qualifying event per state: input falls in idle, every clock otherwise.
  always_comb begin
    case (state_q)
      ST_IDLE: evt = fall;
      ST_WAIT: evt = 1'b1;
      ST_HIGH: evt = 1'b1;
      default: evt = 1'b0;
    endcase
  end

  always_comb begin
    state_d      = state_q;
    cnt_load     = 1'b0;
    cnt_load_val = LOAD_FALL;
    case (state_q)
      ST_IDLE: if (evt && cnt_last) begin
        state_d = ST_WAIT; cnt_load = 1'b1; cnt_load_val = LOAD_WAIT;
      end
      ST_WAIT: if (evt && cnt_last) begin
        state_d = ST_HIGH; cnt_load = 1'b1; cnt_load_val = LOAD_HIGH;
      end
      ST_HIGH: if (evt && cnt_last) begin
        state_d = ST_IDLE; cnt_load = 1'b1; cnt_load_val = LOAD_FALL;
      end
      default: begin
        state_d = ST_IDLE; cnt_load = 1'b1; cnt_load_val = LOAD_FALL;
      end
    endcase
  end

  assign cnt_dec = evt && !cnt_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pulse_o <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_o <= (state_d == ST_HIGH);
    end
  end

  // R1/R7: reset in any state lands in idle with the output low
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (state_q == ST_IDLE && !pulse_o && cnt == LOAD_FALL));

  p_legal_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != ST_BAD);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !fall) |=> (state_q == ST_IDLE && !pulse_o));

  p_wait_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && cnt_last) |=> (state_q == ST_HIGH && pulse_o));

  p_high_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HIGH && cnt_last) |=>
      (state_q == ST_IDLE && !pulse_o && cnt == LOAD_FALL));

  p_wait_ignores_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !cnt_last) |=> (state_q == ST_WAIT && !pulse_o));

endmodule

// File: tb/test_pulse_seq_top.sv
module test_pulse_seq_top;

  localparam int CLK_PERIOD = 10;
  localparam int FALLS = 2;
  localparam int WAITS = 4;
  localparam int HIGHS = 3;
  localparam int SYNCS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b1;
  logic pulse_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int rises = 0;
  logic out_prev = 1'b0;
  bit started = 0;
  string tag = "R1";

  // behavioural reference
  bit mq[$];
  int mst = 0;
  int mcnt = FALLS;
  bit exp_out = 0;

  pulse_seq_top #(
    .FALL_COUNT(FALLS), .WAIT_CYCLES(WAITS), .HIGH_CYCLES(HIGHS), .SYNC_STAGES(SYNCS)
  ) i_pulse_seq_top (
    .clk(clk), .rst_n(rst_n), .din_async(din), .pulse_o(pulse_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    for (int i = 0; i <= SYNCS; i++) mq.push_back(1'b1);
  end

  always @(posedge clk) begin
    bit f;
    cyc <= cyc + 1;
    started = 1;
    if (!rst_n) begin
      mq = {};
      for (int i = 0; i <= SYNCS; i++) mq.push_back(1'b1);
      mst = 0; mcnt = FALLS; exp_out = 0;
    end else begin
      f = (mq[SYNCS-1] == 1'b0) && (mq[SYNCS] == 1'b1) ? 1'b0 : 1'b0;
      // mq[0] is the oldest (edge register), mq[SYNCS] the newest sample
      f = (mq[1] == 1'b0) && (mq[0] == 1'b1);
      if (mst == 0) begin
        if (f) begin
          mcnt--;
          if (mcnt == 0) begin mst = 1; mcnt = WAITS; end
        end
      end else if (mst == 1) begin
        mcnt--;
        if (mcnt == 0) begin mst = 2; mcnt = HIGHS; end
      end else begin
        mcnt--;
        if (mcnt == 0) begin mst = 0; mcnt = FALLS; end
      end
      exp_out = (mst == 2);
      void'(mq.pop_front());
      mq.push_back(din);
    end
  end

  // every-cycle comparison with the reference, plus rise tracking
  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (pulse_o !== exp_out) begin
        failures++;
        $display("FAIL %s cycle %0d pulse_o actual=%0b expected=%0b", tag, cyc, pulse_o, exp_out);
      end
      if (pulse_o === 1'b1 && out_prev !== 1'b1) rises++;
      out_prev = pulse_o;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic one_fall_then_arm(output int m);
    din = 1'b0; step(3);
    din = 1'b1; step(3);
    din = 1'b0; m = cyc;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired at cycle %0d actual=hung expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int m;
    int r0;
    // R1: reset state
    tag = "R1";
    din = 1'b1; rst_n = 1'b0;
    step(3);
    chk("R1", int'(pulse_o), 0);
    rst_n = 1'b1;
    step(20);
    chk("R1", rises, 0);
    chk("R1", int'(pulse_o), 0);

    // R2 / R4 / R5: latency, wait length, pulse width
    tag = "R4";
    one_fall_then_arm(m);
    wait_until(m + SYNCS + WAITS);
    chk("R2", int'(pulse_o), 0);
    wait_until(m + 1 + SYNCS + WAITS);
    chk("R4", int'(pulse_o), 1);
    wait_until(m + SYNCS + WAITS + HIGHS);
    chk("R5", int'(pulse_o), 1);
    wait_until(m + 1 + SYNCS + WAITS + HIGHS);
    chk("R5", int'(pulse_o), 0);
    step(5); din = 1'b1; step(3);

    // R3: rising edges and steady levels are not counted
    tag = "R3";
    r0 = rises;
    din = 1'b0; step(20);
    chk("R3", rises, r0);
    din = 1'b1; step(20);
    chk("R3", rises, r0);
    din = 1'b0; m = cyc;
    wait_until(m + 7);
    chk("R3", int'(pulse_o), 1);
    wait_until(m + 10);
    chk("R3", int'(pulse_o), 0);
    din = 1'b1; step(5);

    // R6: falls during wait and pulse are dropped
    tag = "R6";
    one_fall_then_arm(m);
    wait_until(m + 1); din = 1'b1;
    wait_until(m + 3); din = 1'b0;   // counted in the wait phase slot
    wait_until(m + 4); din = 1'b1;
    wait_until(m + 6); din = 1'b0;   // lands inside the pulse
    wait_until(m + 7);
    chk("R6", int'(pulse_o), 1);
    din = 1'b1;
    wait_until(m + 10);
    chk("R6", int'(pulse_o), 0);
    r0 = rises;
    step(30);
    chk("R6", rises, r0);
    din = 1'b0; step(20);
    chk("R6", rises, r0);
    din = 1'b1; step(3);
    din = 1'b0; m = cyc;
    wait_until(m + 7);
    chk("R6", int'(pulse_o), 1);
    din = 1'b1; step(10);

    // R7: reset in the middle of the wait phase
    tag = "R7";
    one_fall_then_arm(m);
    wait_until(m + 5);
    din = 1'b1; rst_n = 1'b0;
    step(2); rst_n = 1'b1;
    r0 = rises;
    step(20);
    chk("R7", rises, r0);
    chk("R7", int'(pulse_o), 0);

    // R7: reset in the middle of the pulse
    one_fall_then_arm(m);
    wait_until(m + 8);
    chk("R7", int'(pulse_o), 1);
    din = 1'b1; rst_n = 1'b0;
    step(1);
    chk("R7", int'(pulse_o), 0);
    step(1); rst_n = 1'b1;
    r0 = rises;
    step(20);
    chk("R7", rises, r0);

    // R7: partial fall count is discarded by reset
    din = 1'b0; step(3);
    din = 1'b1; step(2);
    rst_n = 1'b0; step(2); rst_n = 1'b1;
    step(3);
    din = 1'b0; step(20);
    chk("R7", rises, r0);
    din = 1'b1; step(3);
    din = 1'b0; m = cyc;
    wait_until(m + 7);
    chk("R7", int'(pulse_o), 1);
    wait_until(m + 10);
    chk("R7", int'(pulse_o), 0);
    din = 1'b1; step(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule